// File: doc/BRIEF.md
# Frame Memory Burst Arbiter

This block shares one external frame memory port among four streaming requesters: host-side transmit, host-side receive, network-side transmit and network-side receive. Each requester keeps two frame-sized buffers of its own. While one buffer fills or drains locally, the requester asks for a burst that moves the other buffer in one piece. A request gives a start word address and a byte count of at most one maximum Ethernet frame (1518 bytes). The arbiter rounds the byte count up to whole 32-bit beats. It then walks consecutive word addresses on the memory side until the burst is done.

Requests use a valid/ready handshake. A requester raises `req_valid` with its address and length and holds all three steady. The arbiter pulses `req_ready` for one cycle in the cycle it takes the request. The requester drops `req_valid` after that cycle and may not raise it again until its burst has finished. The memory side is a valid/ready stream. `mem_valid` is high for the whole burst. A beat is consumed only in a cycle where `mem_ready` is high. When `mem_ready` is low, the current beat, its address and its last flag all hold. Grants cannot be preempted. No other request is taken until the final beat has been consumed, so each burst stays on sequential addresses and page openings stay rare.

Top module: `frame_burst_arbiter`

## Requirements
- R1: After reset, `grant` is all zero, `mem_valid` is low and the round-robin pointer is at requester 0. If all four then request in the same cycle, requester 0 is served first.
- R2: When no burst is active and at least one legal request is present, exactly one `req_ready` bit is high in that cycle. In the next cycle `mem_valid` is high and `grant` equals that one-hot `req_ready` value.
- R3: A burst has exactly ceil(len/4) beats. `mem_last` is high on the final beat only.
- R4: The first beat's `mem_addr` is the requester's start word address. The address rises by exactly 1 after each consumed beat.
- R5: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_last` and `grant` hold their values.
- R6: Once a burst has been granted, `grant` does not change and no `req_ready` is raised until the last beat is consumed. In the cycle after that, `grant` is zero and `mem_valid` is low.
- R7: Among simultaneous legal requests, the next grant goes to the first requesting index at or after (last served index + 1) mod 4, searching upward with wrap-around.
- R8: A request with length 0, or with a length above 1518, is ignored. It never receives `req_ready` or a grant.
- R9: `grant` has at most one bit set. While `mem_valid` is high, `mem_owner` is the binary index of the set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 4 | Per-requester request valid |
| req_addr | input | 4x32 | Per-requester start word address |
| req_len | input | 4x11 | Per-requester burst length in bytes |
| req_ready | output | 4 | One-hot pulse: request accepted this cycle |
| grant | output | 4 | One-hot owner of the active burst, zero when idle |
| mem_valid | output | 1 | A beat is presented to frame memory |
| mem_ready | input | 1 | Frame memory consumes the beat |
| mem_addr | output | 32 | Word address of the current beat |
| mem_last | output | 1 | Current beat is the final beat of the burst |
| mem_owner | output | 2 | Index of the requester that owns the burst |

## Verification
The hardest case to reach is a choice among several waiting requesters made right after a burst ends. That choice exercises the rotating pointer. A back-pressured final beat delays the moment when the pointer moves, which makes the case harder still. The stimulus keeps up to four requests pending at random, with lengths spread from one beat to full frames and illegal lengths mixed in. `mem_ready` is dropped about a quarter of the time, so release, stall and re-arbitration land in many different orders. A directed run starts all four requesters together right after reset and stalls mid-burst, which pins down the first rotation.

// File: rtl/frame_arb_pkg.sv
`timescale 1ns/1ps
package frame_arb_pkg;
  localparam int FA_NUM_REQ    = 4;
  localparam int FA_ADDR_W     = 32;
  localparam int FA_MAX_BYTES  = 1518;
  localparam int FA_BEAT_BYTES = 4;

  function automatic int fa_ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/fba_len_check.sv
`timescale 1ns/1ps
module fba_len_check #(
  parameter int LEN_W      = 11,
  parameter int BEAT_W     = 9,
  parameter int MAX_BYTES  = 1518,
  parameter int BEAT_BYTES = 4
) (
  input  logic [LEN_W-1:0]  len,
  output logic              legal,
  output logic [BEAT_W-1:0] beats
);
  always_comb begin
    legal = (len != '0) && (int'(len) <= MAX_BYTES);
    beats = BEAT_W'(frame_arb_pkg::fa_ceil_div(int'(len), BEAT_BYTES));
  end
endmodule

// File: rtl/fba_rr_picker.sv
`timescale 1ns/1ps
module fba_rr_picker #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic [N-1:0]  pick,
  output logic [IW-1:0] pick_idx,
  output logic          any
);
  always_comb begin
    int idx;
    pick     = '0;
    pick_idx = '0;
    any      = 1'b0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(ptr) + k) % N;
      if (!any && req[idx]) begin
        any       = 1'b1;
        pick[idx] = 1'b1;
        pick_idx  = IW'(idx);
      end
    end
  end
endmodule

// File: rtl/fba_burst_engine.sv
`timescale 1ns/1ps
module fba_burst_engine #(
  parameter int ADDR_W = 32,
  parameter int BEAT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [BEAT_W-1:0] load_beats,
  input  logic              mem_ready,
  output logic              active,
  output logic [ADDR_W-1:0] addr,
  output logic              last,
  output logic              done
);
  logic [BEAT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      addr   <= '0;
      left_q <= '0;
    end else if (load && !active) begin
      active <= 1'b1;
      addr   <= load_addr;
      left_q <= load_beats;
    end else if (active && mem_ready) begin
      if (left_q == BEAT_W'(1)) begin
        active <= 1'b0;
      end else begin
        addr   <= addr + ADDR_W'(1);
        left_q <= left_q - BEAT_W'(1);
      end
    end
  end

  assign last = active && (left_q == BEAT_W'(1));
  assign done = last && mem_ready;
endmodule

// File: rtl/frame_burst_arbiter.sv
`timescale 1ns/1ps
module frame_burst_arbiter #(
  parameter int NUM_REQ    = frame_arb_pkg::FA_NUM_REQ,
  parameter int ADDR_W     = frame_arb_pkg::FA_ADDR_W,
  parameter int MAX_BYTES  = frame_arb_pkg::FA_MAX_BYTES,
  parameter int BEAT_BYTES = frame_arb_pkg::FA_BEAT_BYTES,
  localparam int LEN_W     = $clog2(MAX_BYTES + 1),
  localparam int MAX_BEATS = frame_arb_pkg::fa_ceil_div(MAX_BYTES, BEAT_BYTES),
  localparam int BEAT_W    = $clog2(MAX_BEATS + 1),
  localparam int IDX_W     = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_REQ-1:0]              req_valid,
  input  logic [NUM_REQ-1:0][ADDR_W-1:0]  req_addr,
  input  logic [NUM_REQ-1:0][LEN_W-1:0]   req_len,
  output logic [NUM_REQ-1:0]              req_ready,
  output logic [NUM_REQ-1:0]              grant,
  output logic                            mem_valid,
  input  logic                            mem_ready,
  output logic [ADDR_W-1:0]               mem_addr,
  output logic                            mem_last,
  output logic [IDX_W-1:0]                mem_owner
);
  logic [NUM_REQ-1:0]             legal;
  logic [NUM_REQ-1:0][BEAT_W-1:0] beats;
  logic [NUM_REQ-1:0]             pick;
  logic [IDX_W-1:0]               pick_idx;
  logic                           pick_any;
  logic [IDX_W-1:0]               rr_ptr_q;
  logic [IDX_W-1:0]               owner_q;
  logic                           eng_active;
  logic                           eng_done;
  logic                           accept;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_len
    fba_len_check #(
      .LEN_W(LEN_W), .BEAT_W(BEAT_W),
      .MAX_BYTES(MAX_BYTES), .BEAT_BYTES(BEAT_BYTES)
    ) len_i (
      .len(req_len[g]), .legal(legal[g]), .beats(beats[g])
    );
  end

  fba_rr_picker #(.N(NUM_REQ), .IW(IDX_W)) pick_i (
    .req(req_valid & legal), .ptr(rr_ptr_q),
    .pick(pick), .pick_idx(pick_idx), .any(pick_any)
  );

  assign accept    = pick_any && !eng_active;
  assign req_ready = accept ? pick : '0;

  fba_burst_engine #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) eng_i (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .load_addr(req_addr[pick_idx]), .load_beats(beats[pick_idx]),
    .mem_ready(mem_ready),
    .active(eng_active), .addr(mem_addr), .last(mem_last), .done(eng_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant    <= '0;
      owner_q  <= '0;
      rr_ptr_q <= '0;
    end else if (accept) begin
      grant   <= pick;
      owner_q <= pick_idx;
    end else if (eng_done) begin
      grant    <= '0;
      rr_ptr_q <= (owner_q == IDX_W'(NUM_REQ - 1)) ? '0 : owner_q + IDX_W'(1);
    end
  end

  assign mem_valid = eng_active;
  assign mem_owner = owner_q;
endmodule

// File: rtl/fba_checker.sv
`timescale 1ns/1ps
module fba_checker #(
  parameter int NUM_REQ   = 4,
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 11,
  parameter int MAX_BYTES = 1518,
  parameter int IDX_W     = 2
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_REQ-1:0][LEN_W-1:0]  req_len,
  input logic [NUM_REQ-1:0]             req_ready,
  input logic [NUM_REQ-1:0]             grant,
  input logic                           mem_valid,
  input logic                           mem_ready,
  input logic [ADDR_W-1:0]              mem_addr,
  input logic                           mem_last,
  input logic [IDX_W-1:0]               mem_owner
);
  assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> grant[mem_owner]);
  assert_valid_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid == (grant != '0));
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready != '0) |=> mem_valid && (grant == $past(req_ready)));
  assert_ready_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));
  assert_no_ready_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (req_ready == '0));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr) && $stable(mem_last) && $stable(grant));
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_last) |=>
      mem_valid && (mem_addr == $past(mem_addr) + ADDR_W'(1)) && $stable(grant));
  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_last) |=> !mem_valid && (grant == '0));

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_len
    assert_legal_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready[g] |-> ((req_len[g] != '0) && (int'(req_len[g]) <= MAX_BYTES)));
  end
endmodule

bind frame_burst_arbiter fba_checker #(
  .NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
  .MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_len(req_len), .req_ready(req_ready),
  .grant(grant), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_last(mem_last), .mem_owner(mem_owner)
);

// File: tb/frame_burst_arbiter_tb_top.sv
`timescale 1ns/1ps
module frame_burst_arbiter_tb_top;
  localparam int NR   = 4;
  localparam int AW   = 32;
  localparam int LW   = 11;
  localparam int MAXB = 1518;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NR-1:0]      req_valid = '0;
  logic [NR-1:0][AW-1:0] req_addr = '0;
  logic [NR-1:0][LW-1:0] req_len = '0;
  logic [NR-1:0]      req_ready;
  logic [NR-1:0]      grant;
  logic               mem_valid;
  logic               mem_ready = 1'b0;
  logic [AW-1:0]      mem_addr;
  logic               mem_last;
  logic [1:0]         mem_owner;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  bit          m_busy = 0;
  int          m_owner = 0;
  logic [AW-1:0] m_addr = '0;
  int          m_left = 0;
  int          m_ptr = 0;

  always #2 clk = ~clk;

  frame_burst_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .req_ready(req_ready), .grant(grant),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_last(mem_last), .mem_owner(mem_owner)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic bit legal_req(input int i);
    return req_valid[i] && req_len[i] != 0 && int'(req_len[i]) <= MAXB;
  endfunction

  function automatic int rr_pick();
    for (int k = 0; k < NR; k++) begin
      if (legal_req((m_ptr + k) % NR)) return (m_ptr + k) % NR;
    end
    return -1;
  endfunction

  task automatic step();
    int p;
    logic [NR-1:0] exp_ready;
    @(negedge clk);
    p = m_busy ? -1 : rr_pick();
    exp_ready = (p >= 0) ? NR'(1 << p) : '0;
    chk(req_ready == exp_ready, "R2 R7 R8 req_ready", req_ready, exp_ready);
    chk(mem_valid == m_busy, "R2 mem_valid", mem_valid, m_busy);
    if (m_busy) begin
      chk(mem_addr == m_addr, "R4 mem_addr", mem_addr, m_addr);
      chk(mem_last == (m_left == 1), "R3 mem_last", mem_last, m_left == 1);
      chk(grant == NR'(1 << m_owner), "R6 grant", grant, 1 << m_owner);
      chk(int'(mem_owner) == m_owner, "R9 mem_owner", mem_owner, m_owner);
    end else begin
      chk(grant == '0, "R6 grant idle", grant, 0);
    end
    if (p >= 0) begin
      m_busy  = 1;
      m_owner = p;
      m_addr  = req_addr[p];
      m_left  = (int'(req_len[p]) + 3) / 4;
    end else if (m_busy && mem_ready) begin
      if (m_left == 1) begin
        m_busy = 0;
        m_ptr  = (m_owner + 1) % NR;
      end else begin
        m_addr = m_addr + 1;
        m_left = m_left - 1;
      end
    end
    @(posedge clk);
    #1;
    req_valid = req_valid & ~exp_ready;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int guard;
    void'($urandom(32'h5EED));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(grant == '0, "R1 grant after reset", grant, 0);
    chk(mem_valid == 1'b0, "R1 mem_valid after reset", mem_valid, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R8: zero and oversize lengths ignored
    mem_ready = 1'b1;
    req_valid = 4'b1010;
    req_len[1] = 0;
    req_len[3] = 11'd1600;
    repeat (6) step();
    chk(mem_valid == 1'b0 && grant == '0, "R8 illegal ignored", {grant, mem_valid}, 0);
    req_valid = '0;

    // R1 R7: all four together, lengths 5,1,1518,8, stall mid-burst (R5)
    for (int i = 0; i < NR; i++) req_addr[i] = AW'(32'h1000 * (i + 1));
    req_len[0] = 5; req_len[1] = 1; req_len[2] = 1518; req_len[3] = 8;
    req_valid = 4'b1111;
    step(); step();
    mem_ready = 1'b0;
    repeat (3) step();
    mem_ready = 1'b1;
    guard = 0;
    while ((req_valid != '0 || m_busy) && guard < 2000) begin
      step();
      guard++;
    end
    chk(m_ptr == 0 && mem_valid == 1'b0, "R7 rotation back to 0", m_ptr, 0);

    // Random phase
    for (int c = 0; c < 30000; c++) begin
      for (int i = 0; i < NR; i++) begin
        if (req_valid[i] && !legal_req(i) && ($urandom % 4 == 0)) req_valid[i] = 1'b0;
        if (!req_valid[i] && !(m_busy && m_owner == i) && ($urandom % 8 == 0)) begin
          int r;
          r = $urandom % 16;
          req_addr[i] = $urandom;
          if (r == 0)      req_len[i] = 0;
          else if (r == 1) req_len[i] = 11'd1518;
          else if (r == 2) req_len[i] = 11'd1;
          else if (r == 3) req_len[i] = LW'(1519 + $urandom % 400);
          else             req_len[i] = LW'(1 + $urandom % 400);
          req_valid[i] = 1'b1;
        end
      end
      mem_ready = ($urandom % 4) != 0;
      step();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule